// File: doc/BRIEF.md
# AXI-Lite Slave Protocol Guard

This block is placed in series between an AXI-Lite master and a single AXI-Lite slave. While the slave behaves, address, write data and responses travel through it without added latency. It counts the requests the master has handed over on each request channel and watches the slave's response channels against that ledger.

When the slave sends a response nobody asked for, changes or withdraws a response before it is taken, or leaves a request unanswered for too long, the guard cuts the slave off. From then on the guard answers every request still owed and every new one with an error response, so the master can always finish. A sticky fault flag is raised for an on-chip logic analyzer to trigger on. When recovery is enabled, a reset pulse of fixed length goes to the slave. Normal forwarding resumes once the pulse is over and every request still owed upstream has been answered.

Top module: `axil_guard`

## Requirements
- R1: While no fault has been seen, AW, W and AR payloads reach the slave unchanged in the same cycle, and the slave's B and R payloads (response codes and read data) reach the master unchanged in the same cycle.
- R2: Each request channel (AW, W, AR) accepts at most MAX_OUT requests that have not been answered yet; at that count its upstream ready and its downstream valid stay low.
- R3: A slave BVALID while no write has both its address and its data accepted, or a slave RVALID while no read address is outstanding, is a violation. This includes the first cycle after reset is released. The response is not forwarded.
- R4: Once the slave holds BVALID or RVALID without a ready, lowering the valid or changing the payload in a later cycle is a violation.
- R5: A write whose address and data are both accepted, or an accepted read, that gets no response for TIMEOUT+1 consecutive cycles is a violation. The output `fault` rises after the (TIMEOUT+1)-th clock edge that follows the acceptance.
- R6: `fault` is 0 after reset. It rises in the cycle after the first violation and stays 1 until the next reset.
- R7: While isolated, the guard keeps all downstream request valids low and holds the downstream BREADY and RREADY high.
- R8: While isolated, the guard answers every write and read owed to the master, whether accepted before or after the violation, with exactly one response carrying code 2'b10 (error). Read data on these responses is zero.
- R9: With RECOVER=1, `dn_rst_n` is low for exactly RST_CYCLES cycles, starting in the cycle after the violation.
- R10: After the reset pulse, and once no request is owed upstream, forwarding resumes as in R1. `fault` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_awaddr | input | ADDR_W | Write address from master |
| up_awprot | input | 3 | Write protection from master |
| up_awvalid | input | 1 | Write address valid from master |
| up_awready | output | 1 | Write address ready to master |
| up_wdata | input | DATA_W | Write data from master |
| up_wstrb | input | DATA_W/8 | Write strobes from master |
| up_wvalid | input | 1 | Write data valid from master |
| up_wready | output | 1 | Write data ready to master |
| up_bresp | output | 2 | Write response code to master |
| up_bvalid | output | 1 | Write response valid to master |
| up_bready | input | 1 | Write response ready from master |
| up_araddr | input | ADDR_W | Read address from master |
| up_arprot | input | 3 | Read protection from master |
| up_arvalid | input | 1 | Read address valid from master |
| up_arready | output | 1 | Read address ready to master |
| up_rdata | output | DATA_W | Read data to master |
| up_rresp | output | 2 | Read response code to master |
| up_rvalid | output | 1 | Read valid to master |
| up_rready | input | 1 | Read ready from master |
| dn_awaddr | output | ADDR_W | Write address to slave |
| dn_awprot | output | 3 | Write protection to slave |
| dn_awvalid | output | 1 | Write address valid to slave |
| dn_awready | input | 1 | Write address ready from slave |
| dn_wdata | output | DATA_W | Write data to slave |
| dn_wstrb | output | DATA_W/8 | Write strobes to slave |
| dn_wvalid | output | 1 | Write data valid to slave |
| dn_wready | input | 1 | Write data ready from slave |
| dn_bresp | input | 2 | Write response code from slave |
| dn_bvalid | input | 1 | Write response valid from slave |
| dn_bready | output | 1 | Write response ready to slave |
| dn_araddr | output | ADDR_W | Read address to slave |
| dn_arprot | output | 3 | Read protection to slave |
| dn_arvalid | output | 1 | Read address valid to slave |
| dn_arready | input | 1 | Read address ready from slave |
| dn_rdata | input | DATA_W | Read data from slave |
| dn_rresp | input | 2 | Read response code from slave |
| dn_rvalid | input | 1 | Read valid from slave |
| dn_rready | output | 1 | Read ready to slave |
| fault | output | 1 | Sticky violation flag |
| dn_rst_n | output | 1 | Active-low reset toward the slave |

## Verification
Forwarding is tried with writes and reads whose data are all-zero, all-one and alternating, with response delays from zero to several cycles, and with the slave's own error code. This shows that payloads, codes and handshakes cross unchanged and that legal slow responses are not mistaken for faults. Each fault kind is then provoked separately: a read response in the first cycle after reset, read data that changes while the response waits, and a write that is never answered. Each case shows that its own detector fires and that a request owed from before the fault gets a substitute error. Filling a read channel to its limit shows back-pressure. The last case counts the low cycles of the slave reset and sends a normal write afterwards to show that forwarding resumes.

// File: rtl/axil_guard_pkg.sv
`timescale 1ns/1ps
package axil_guard_pkg;
    typedef enum logic {
        ST_PASS    = 1'b0,
        ST_ISOLATE = 1'b1
    } guard_st_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    // request channel indices
    localparam int CH_AW    = 0;
    localparam int CH_W     = 1;
    localparam int CH_AR    = 2;
    localparam int N_REQ_CH = 3;

    // response channel indices
    localparam int MON_B    = 0;
    localparam int MON_R    = 1;
    localparam int N_RSP_CH = 2;
endpackage

// File: rtl/axil_guard_ledger.sv
`timescale 1ns/1ps
// Counts requests accepted upstream and not yet answered on one channel.
module axil_guard_ledger #(
    parameter  int MAX_OUT = 4,
    localparam int CW      = $clog2(MAX_OUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case ({inc, dec})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full = (cnt_q == CW'(MAX_OUT));
    assign busy = (cnt_q != '0);
endmodule

// File: rtl/axil_guard_wdog.sv
`timescale 1ns/1ps
// Counts cycles without progress while a response is owed.
module axil_guard_wdog #(
    parameter  int LIMIT = 16,
    localparam int TW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    logic [TW-1:0] tmr_d, tmr_q;

    always_comb begin
        if (clear || !run)             tmr_d = '0;
        else if (tmr_q == TW'(LIMIT))  tmr_d = tmr_q;
        else                           tmr_d = tmr_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = run && (tmr_q == TW'(LIMIT));
endmodule

// File: rtl/axil_guard_hold.sv
`timescale 1ns/1ps
// Flags a response that is withdrawn or altered while it waits for ready.
module axil_guard_hold #(
    parameter int PW = 34
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          valid,
    input  logic          ready,
    input  logic [PW-1:0] payload,
    output logic          bad
);
    logic          wait_d, wait_q;
    logic [PW-1:0] pl_d, pl_q;

    always_comb begin
        wait_d = en && valid && !ready;
        pl_d   = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            pl_q   <= '0;
        end else begin
            wait_q <= wait_d;
            pl_q   <= pl_d;
        end
    end

    assign bad = en && wait_q && (!valid || (payload != pl_q));
endmodule

// File: rtl/axil_guard.sv
`timescale 1ns/1ps
module axil_guard
    import axil_guard_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int DATA_W     = 32,
    parameter  int MAX_OUT    = 4,
    parameter  int TIMEOUT    = 16,
    parameter  int RST_CYCLES = 4,
    parameter  bit RECOVER    = 1'b1,
    localparam int STRB_W     = DATA_W / 8,
    localparam int RW         = $clog2(RST_CYCLES + 1),
    localparam int PW         = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] up_awaddr,
    input  logic [2:0]        up_awprot,
    input  logic              up_awvalid,
    output logic              up_awready,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [STRB_W-1:0] up_wstrb,
    input  logic              up_wvalid,
    output logic              up_wready,
    output logic [1:0]        up_bresp,
    output logic              up_bvalid,
    input  logic              up_bready,
    input  logic [ADDR_W-1:0] up_araddr,
    input  logic [2:0]        up_arprot,
    input  logic              up_arvalid,
    output logic              up_arready,
    output logic [DATA_W-1:0] up_rdata,
    output logic [1:0]        up_rresp,
    output logic              up_rvalid,
    input  logic              up_rready,
    output logic [ADDR_W-1:0] dn_awaddr,
    output logic [2:0]        dn_awprot,
    output logic              dn_awvalid,
    input  logic              dn_awready,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [STRB_W-1:0] dn_wstrb,
    output logic              dn_wvalid,
    input  logic              dn_wready,
    input  logic [1:0]        dn_bresp,
    input  logic              dn_bvalid,
    output logic              dn_bready,
    output logic [ADDR_W-1:0] dn_araddr,
    output logic [2:0]        dn_arprot,
    output logic              dn_arvalid,
    input  logic              dn_arready,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_rresp,
    input  logic              dn_rvalid,
    output logic              dn_rready,
    output logic              fault,
    output logic              dn_rst_n
);
    typedef struct packed {
        guard_st_e     st;
        logic [RW-1:0] rcnt;
        logic          fault;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic isolated;

    // ledgers of owed responses, one per request channel
    logic [N_REQ_CH-1:0] req_inc, req_dec, req_full, req_busy;
    logic wr_due, rd_due, up_b_hs, up_r_hs, drained;

    generate
        for (genvar g = 0; g < N_REQ_CH; g++) begin : g_ledger
            axil_guard_ledger #(.MAX_OUT(MAX_OUT)) u_ledger (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (req_inc[g]),
                .dec  (req_dec[g]),
                .full (req_full[g]),
                .busy (req_busy[g])
            );
        end
    endgenerate

    assign req_inc[CH_AW] = up_awvalid && up_awready;
    assign req_inc[CH_W]  = up_wvalid  && up_wready;
    assign req_inc[CH_AR] = up_arvalid && up_arready;
    assign up_b_hs        = up_bvalid  && up_bready;
    assign up_r_hs        = up_rvalid  && up_rready;
    assign req_dec[CH_AW] = up_b_hs;
    assign req_dec[CH_W]  = up_b_hs;
    assign req_dec[CH_AR] = up_r_hs;

    assign wr_due  = req_busy[CH_AW] && req_busy[CH_W];
    assign rd_due  = req_busy[CH_AR];
    assign drained = !(|req_busy);

    // response hold monitors
    logic [N_RSP_CH-1:0] mon_valid, mon_ready, hold_bad;
    logic [PW-1:0]       mon_pl [N_RSP_CH];

    assign mon_valid[MON_B] = dn_bvalid;
    assign mon_ready[MON_B] = dn_bready;
    assign mon_pl[MON_B]    = PW'(dn_bresp);
    assign mon_valid[MON_R] = dn_rvalid;
    assign mon_ready[MON_R] = dn_rready;
    assign mon_pl[MON_R]    = {dn_rresp, dn_rdata};

    generate
        for (genvar g = 0; g < N_RSP_CH; g++) begin : g_hold
            axil_guard_hold #(.PW(PW)) u_hold (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (!isolated),
                .valid  (mon_valid[g]),
                .ready  (mon_ready[g]),
                .payload(mon_pl[g]),
                .bad    (hold_bad[g])
            );
        end
    endgenerate

    // progress watchdogs, write and read
    logic [1:0] wd_run, wd_clr, wd_exp;

    assign wd_run[0] = !isolated && wr_due;
    assign wd_clr[0] = up_b_hs;
    assign wd_run[1] = !isolated && rd_due;
    assign wd_clr[1] = up_r_hs;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_wdog
            axil_guard_wdog #(.LIMIT(TIMEOUT)) u_wdog (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (wd_run[g]),
                .clear  (wd_clr[g]),
                .expired(wd_exp[g])
            );
        end
    endgenerate

    logic unsolicited, violation;
    assign unsolicited = (dn_bvalid && !wr_due) || (dn_rvalid && !rd_due);
    assign violation   = !isolated && (unsolicited || (|hold_bad) || (|wd_exp));

    // datapath steering
    always_comb begin
        dn_awaddr  = up_awaddr;
        dn_awprot  = up_awprot;
        dn_wdata   = up_wdata;
        dn_wstrb   = up_wstrb;
        dn_araddr  = up_araddr;
        dn_arprot  = up_arprot;
        if (!isolated) begin
            dn_awvalid = up_awvalid && !req_full[CH_AW];
            up_awready = dn_awready && !req_full[CH_AW];
            dn_wvalid  = up_wvalid  && !req_full[CH_W];
            up_wready  = dn_wready  && !req_full[CH_W];
            dn_arvalid = up_arvalid && !req_full[CH_AR];
            up_arready = dn_arready && !req_full[CH_AR];
            up_bvalid  = dn_bvalid && wr_due;
            up_bresp   = dn_bresp;
            dn_bready  = up_bready && wr_due;
            up_rvalid  = dn_rvalid && rd_due;
            up_rdata   = dn_rdata;
            up_rresp   = dn_rresp;
            dn_rready  = up_rready && rd_due;
        end else begin
            dn_awvalid = 1'b0;
            dn_wvalid  = 1'b0;
            dn_arvalid = 1'b0;
            up_awready = !req_full[CH_AW];
            up_wready  = !req_full[CH_W];
            up_arready = !req_full[CH_AR];
            up_bvalid  = wr_due;
            up_bresp   = RESP_SLVERR;
            dn_bready  = 1'b1;
            up_rvalid  = rd_due;
            up_rdata   = '0;
            up_rresp   = RESP_SLVERR;
            dn_rready  = 1'b1;
        end
    end

    // control state
    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_PASS: begin
                if (violation) begin
                    ctl_d.st    = ST_ISOLATE;
                    ctl_d.rcnt  = '0;
                    ctl_d.fault = 1'b1;
                end
            end
            ST_ISOLATE: begin
                if (ctl_q.rcnt != RW'(RST_CYCLES))
                    ctl_d.rcnt = ctl_q.rcnt + RW'(1);
                else if (RECOVER && drained)
                    ctl_d.st = ST_PASS;
            end
            default: ctl_d.st = ST_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_PASS, rcnt: '0, fault: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign isolated = (ctl_q.st == ST_ISOLATE);
    assign fault    = ctl_q.fault;
    assign dn_rst_n = rst_n && !(RECOVER && isolated && (ctl_q.rcnt != RW'(RST_CYCLES)));
endmodule

// File: rtl/axil_guard_sva.sv
`timescale 1ns/1ps
module axil_guard_sva #(
    parameter bit RECOVER = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       isolated,
    input logic       fault,
    input logic       dn_rst_n,
    input logic       dn_awvalid,
    input logic       dn_wvalid,
    input logic       dn_arvalid,
    input logic       dn_bready,
    input logic       dn_rready,
    input logic       dn_bvalid,
    input logic       dn_rvalid,
    input logic       up_awready,
    input logic       up_arready,
    input logic       up_bvalid,
    input logic [1:0] up_bresp,
    input logic       up_rvalid,
    input logic       up_rready,
    input logic [1:0] up_rresp,
    input logic [2:0] req_full,
    input logic       wr_due,
    input logic       rd_due
);
    p_no_overflow_aw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_full[0] |-> !up_awready);

    p_no_overflow_ar_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_full[2] |-> !up_arready);

    p_unsolicited_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!isolated && ((dn_bvalid && !wr_due) || (dn_rvalid && !rd_due))) |=> fault);

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    p_iso_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isolated |-> (!dn_awvalid && !dn_wvalid && !dn_arvalid && dn_bready && dn_rready));

    p_err_bresp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isolated && up_bvalid) |-> (up_bresp == 2'b10));

    p_err_rresp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isolated && up_rvalid) |-> (up_rresp == 2'b10));

    p_err_rhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isolated && up_rvalid && !up_rready) |=> up_rvalid);

    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault) && RECOVER) |-> !dn_rst_n);
endmodule

bind axil_guard axil_guard_sva #(.RECOVER(RECOVER)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .isolated  (isolated),
    .fault     (fault),
    .dn_rst_n  (dn_rst_n),
    .dn_awvalid(dn_awvalid),
    .dn_wvalid (dn_wvalid),
    .dn_arvalid(dn_arvalid),
    .dn_bready (dn_bready),
    .dn_rready (dn_rready),
    .dn_bvalid (dn_bvalid),
    .dn_rvalid (dn_rvalid),
    .up_awready(up_awready),
    .up_arready(up_arready),
    .up_bvalid (up_bvalid),
    .up_bresp  (up_bresp),
    .up_rvalid (up_rvalid),
    .up_rready (up_rready),
    .up_rresp  (up_rresp),
    .req_full  (req_full),
    .wr_due    (wr_due),
    .rd_due    (rd_due)
);

// File: tb/axil_guard_bench.sv
`timescale 1ns/1ps
module axil_guard_bench;
    localparam int TO   = 16;
    localparam int RSTC = 4;
    localparam int MOUT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] up_awaddr, up_wdata, up_araddr, up_rdata;
    logic [2:0]  up_awprot, up_arprot;
    logic [3:0]  up_wstrb;
    logic        up_awvalid, up_awready, up_wvalid, up_wready;
    logic [1:0]  up_bresp, up_rresp;
    logic        up_bvalid, up_bready, up_arvalid, up_arready, up_rvalid, up_rready;
    logic [31:0] dn_awaddr, dn_wdata, dn_araddr, dn_rdata;
    logic [2:0]  dn_awprot, dn_arprot;
    logic [3:0]  dn_wstrb;
    logic        dn_awvalid, dn_awready, dn_wvalid, dn_wready;
    logic [1:0]  dn_bresp, dn_rresp;
    logic        dn_bvalid, dn_bready, dn_arvalid, dn_arready, dn_rvalid, dn_rready;
    logic        fault, dn_rst_n;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    axil_guard #(.MAX_OUT(MOUT), .TIMEOUT(TO), .RST_CYCLES(RSTC), .RECOVER(1'b1)) u_axil_guard (.*);

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  lat;
        logic [1:0]  rsp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 32'h0000_0010, 32'h0000_0000, 4'd0, 2'b00},
        '{1'b0, 32'h0000_0010, 32'hFFFF_FFFF, 4'd0, 2'b00},
        '{1'b1, 32'h0000_0024, 32'hAAAA_5555, 4'd3, 2'b00},
        '{1'b0, 32'h0000_0024, 32'h5555_AAAA, 4'd5, 2'b00},
        '{1'b1, 32'h8000_0000, 32'h1234_5678, 4'd1, 2'b10},
        '{1'b0, 32'hFFFF_FFFC, 32'hDEAD_BEEF, 4'd2, 2'b10},
        '{1'b1, 32'h0000_0100, 32'hFFFF_FFFF, 4'd7, 2'b00},
        '{1'b0, 32'h0000_0104, 32'h0F0F_0F0F, 4'd1, 2'b00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        up_awaddr = '0; up_awprot = '0; up_awvalid = 0; up_wdata = '0; up_wstrb = '0;
        up_wvalid = 0; up_bready = 0; up_araddr = '0; up_arprot = '0; up_arvalid = 0;
        up_rready = 0; dn_awready = 0; dn_wready = 0; dn_bresp = '0; dn_bvalid = 0;
        dn_arready = 0; dn_rdata = '0; dn_rresp = '0; dn_rvalid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr_txn(input logic [31:0] a, input logic [31:0] d, input int lat,
                          input logic [1:0] rsp, input string tag);
        @(negedge clk);
        up_awaddr = a; up_awprot = 3'd2; up_wdata = d; up_wstrb = 4'hF;
        up_awvalid = 1; up_wvalid = 1; up_bready = 1; dn_awready = 1; dn_wready = 1;
        #1;
        chk({tag, " awaddr"}, dn_awaddr, a);
        chk({tag, " wdata"}, dn_wdata, d);
        chk({tag, " aw/w valid"}, {dn_awvalid, dn_wvalid, up_awready, up_wready}, 4'hF);
        @(negedge clk);
        up_awvalid = 0; up_wvalid = 0; dn_awready = 0; dn_wready = 0;
        repeat (lat) @(negedge clk);
        dn_bvalid = 1; dn_bresp = rsp;
        #1;
        chk({tag, " bvalid/bresp"}, {up_bvalid, up_bresp}, {1'b1, rsp});
        @(negedge clk);
        dn_bvalid = 0; up_bready = 0;
    endtask

    task automatic rd_txn(input logic [31:0] a, input logic [31:0] d, input int lat,
                          input logic [1:0] rsp, input string tag);
        @(negedge clk);
        up_araddr = a; up_arprot = 3'd1; up_arvalid = 1; up_rready = 1; dn_arready = 1;
        #1;
        chk({tag, " araddr"}, dn_araddr, a);
        chk({tag, " ar valid"}, {dn_arvalid, up_arready}, 2'b11);
        @(negedge clk);
        up_arvalid = 0; dn_arready = 0;
        repeat (lat) @(negedge clk);
        dn_rvalid = 1; dn_rdata = d; dn_rresp = rsp;
        #1;
        chk({tag, " rvalid/rresp/rdata"}, {up_rvalid, up_rresp, up_rdata}, {1'b1, rsp, d});
        @(negedge clk);
        dn_rvalid = 0; up_rready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        idle_all();
        do_reset();
        #1;
        // R6 reset state
        chk("R6 reset fault", fault, 0);
        chk("R6 reset outputs", {dn_rst_n, up_bvalid, up_rvalid}, 3'b100);

        // R1 table of legal transactions
        for (int i = 0; i < 8; i++) begin
            if (VECS[i].wr) wr_txn(VECS[i].addr, VECS[i].data, int'(VECS[i].lat), VECS[i].rsp, "R1 wr");
            else            rd_txn(VECS[i].addr, VECS[i].data, int'(VECS[i].lat), VECS[i].rsp, "R1 rd");
        end
        chk("R1 no false fault", fault, 0);

        // R2 outstanding limit on AR
        @(negedge clk);
        up_araddr = 32'h40; up_arvalid = 1; dn_arready = 1; up_rready = 0;
        repeat (MOUT) @(negedge clk);
        #1;
        chk("R2 arready at limit", {up_arready, dn_arvalid}, 2'b00);
        up_arvalid = 0; dn_arready = 0;
        dn_rvalid = 1; dn_rdata = 32'h77; up_rready = 1;
        repeat (MOUT) @(negedge clk);
        dn_rvalid = 0; up_rready = 0;
        @(negedge clk);
        up_arvalid = 1; dn_arready = 1;
        #1;
        chk("R2 arready after drain", up_arready, 1);
        up_arvalid = 0; dn_arready = 0;
        chk("R2 no fault", fault, 0);
        @(negedge clk);
        // the probe above was not accepted: no edge passed while valid was set

        // R5 write timeout, then R8 substitute responses, R7 isolation
        do_reset();
        up_awaddr = 32'h8; up_wdata = 32'h99; up_awvalid = 1; up_wvalid = 1;
        dn_awready = 1; dn_wready = 1;
        @(negedge clk);
        up_awvalid = 0; up_wvalid = 0; dn_awready = 0; dn_wready = 0;
        repeat (TO) @(negedge clk);
        chk("R5 no fault before limit", fault, 0);
        @(negedge clk);
        chk("R5 fault after limit", fault, 1);
        #1;
        chk("R8 owed write gets error", {up_bvalid, up_bresp}, 3'b110);
        chk("R7 downstream readies", {dn_bready, dn_rready}, 2'b11);
        up_bready = 1;
        @(negedge clk);
        up_bready = 0;
        up_arvalid = 1; up_araddr = 32'h10; dn_arready = 1;
        #1;
        chk("R7 no downstream ar", dn_arvalid, 0);
        chk("R8 new read accepted", up_arready, 1);
        @(negedge clk);
        up_arvalid = 0; dn_arready = 0;
        #1;
        chk("R8 new read error", {up_rvalid, up_rresp, up_rdata}, {1'b1, 2'b10, 32'h0});
        up_rready = 1;
        @(negedge clk);
        #1;
        chk("R8 single response", up_rvalid, 0);
        up_rready = 0;

        // R4 read data altered while waiting
        do_reset();
        up_araddr = 32'h20; up_arvalid = 1; dn_arready = 1;
        @(negedge clk);
        up_arvalid = 0; dn_arready = 0;
        dn_rvalid = 1; dn_rdata = 32'hAAAA; up_rready = 0;
        @(negedge clk);
        chk("R4 stable wait ok", fault, 0);
        dn_rdata = 32'hBBBB;
        @(negedge clk);
        chk("R4 changed payload faults", fault, 1);
        dn_rvalid = 0;
        #1;
        chk("R8 owed read error", {up_rvalid, up_rresp, up_rdata}, {1'b1, 2'b10, 32'h0});

        // R3 response in first cycle after reset, R9 pulse, R10 resume
        @(negedge clk);
        rst_n = 0;
        idle_all();
        dn_rvalid = 1; dn_rdata = 32'h5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R3 not forwarded", up_rvalid, 0);
        @(negedge clk);
        chk("R3 first-cycle valid faults", fault, 1);
        dn_rvalid = 0;
        begin
            int lows;
            lows = 0;
            for (int k = 0; k < 8; k++) begin
                if (!dn_rst_n) lows++;
                @(negedge clk);
            end
            chk("R9 reset pulse length", lows, RSTC);
        end
        wr_txn(32'h30, 32'hC0FFEE, 1, 2'b00, "R10 resume");
        chk("R6 fault still set", fault, 1);

        do_reset();
        #1;
        chk("R6 cleared by reset", fault, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule